// File: doc/BRIEF.md
# Smartcard character link with error-signal handling

This block is the character layer of a half-duplex smartcard serial interface. It shares one open-drain data line with the card. It sends and receives characters made of a low start bit, eight data bits sent least significant bit first, and an even-parity bit. Time on the line is counted in elementary time units (etu). Each etu is split into a fixed number of oversampling ticks, and a programmable clock divider sets the length of one tick. Every bit is sampled at the middle of its etu.

When the block receives a character with bad parity, it pulls the line low from 10.5 etu after the start edge until 12 etu. This asks the card to send the character again. When the block transmits, it releases the line after the parity bit and reads the line at 11 etu to find out whether the card is signalling an error. After an error it waits out the guard time and sends the same byte again. It does this up to a programmed number of retries, then reports failure. A card error pulse may begin late in the guard window, for example at 10.68 etu. Such a pulse is still taken as an error signal and never as the start of a new character, because the start detector stays disabled from a start edge until the end of that character's guard time.

The divider and the retry count are captured only while `enable` is low. A user sets them, then raises `enable`. The bench and the requirements assume 16 ticks per etu and a 2 etu guard time. With these values, a frame that ends cleanly lasts 12 etu, and an error-signalled frame lasts 14 etu before a resend.

Top module: `smartcard_char_link`

## Requirements
- R1: After reset the line is not driven and no event output pulses. `tx_ready` follows `enable` while the block is idle.
- R2: A transmitted character drives the line low for the start bit from its first etu. Etu k (k = 1..8) carries data bit k-1, with a low line for a 0. Etu 9 carries the XOR of the eight data bits. From 10 etu onward the line is released.
- R3: If the line is high at the 11 etu sample point, `tx_done` pulses for one cycle exactly 12 etu after the start edge, and the block is ready for the next byte.
- R4: If the line is low at the 11 etu sample point, the block starts the same character again with a new start bit at 14 etu. An error pulse whose falling edge comes as late as 10.68 etu counts as an error.
- R5: A late error pulse on a transmitted character is never taken as a received start bit. No receive event follows it.
- R6: With a retry count N (0 to 7), at most N resends are made. If the card flags an error on attempt N+1, `tx_fail` pulses at 14 etu of that attempt and no `tx_done` is given.
- R7: A received character with correct even parity pulses `rx_valid` at 12 etu after its start edge, with the byte on `rx_data`. The line is never driven during this character.
- R8: A received character with wrong parity drives the line low from 10.5 etu to 12 etu after the start edge and pulses `rx_parity_err` at 12 etu. `rx_valid` does not pulse.
- R9: Falling edges on the line are ignored from a start edge until the end of that character's guard time. A low that is no longer present at the middle of the start bit is dropped without any event.
- R10: One oversampling tick lasts `cfg_div` clock cycles (0 is treated as 1). Changes to `cfg_div` or `cfg_retries` made while `enable` is high have no effect on timing or retries.
- R11: Lowering `enable` releases the line within one clock, aborts any character in progress without an event, and lowers `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; configuration is captured while low |
| cfg_div | input | DIV_W | Clock cycles per oversampling tick |
| cfg_retries | input | RETRY_W | Maximum resends after an error signal |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Idle and enabled; a byte is accepted |
| tx_done | output | 1 | One-cycle pulse: character sent without error signal |
| tx_fail | output | 1 | One-cycle pulse: retries exhausted, byte dropped |
| rx_valid | output | 1 | One-cycle pulse: good character received |
| rx_data | output | 8 | Last received byte |
| rx_parity_err | output | 1 | One-cycle pulse: character with bad parity received |
| line_in | input | 1 | Sensed level of the data line |
| line_drive_low | output | 1 | Pull the data line low when high |

## Verification
An off-by-one in the etu or tick counters shows up within one character. Data bits get shifted in the received byte, the error pulse moves off the 10.5–12 etu window, or the done and fail pulses land a whole etu early or late. These errors are caught by sampling the line and the pulses at exact clock offsets from the start edge. An error flag or retry counter in the wrong state shows up within one or two frames as a missing resend start bit at 14 etu, an extra attempt, or `tx_done` in place of `tx_fail`. A start detector that was armed too early would only show up as a phantom receive event a few hundred cycles later, so those tests watch a long quiet window after each late line transition.

// File: rtl/sc_char_pkg.sv
package sc_char_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2
  } sc_state_e;

  // Even parity: the parity bit makes the total count of ones even.
  function automatic logic sc_even_parity(input logic [7:0] d);
    return ^d;
  endfunction

  // Level of character bit idx: 0 start, 1..8 data LSB first, 9 parity.
  function automatic logic sc_frame_bit(input logic [7:0] d, input logic [3:0] idx);
    logic [9:0] frame;
    frame = {sc_even_parity(d), d, 1'b0};
    return (idx <= 4'd9) ? frame[idx] : 1'b1;
  endfunction

  // True when a received byte and its parity bit disagree.
  function automatic logic sc_parity_bad(input logic [7:0] d, input logic par);
    return sc_even_parity(d) != par;
  endfunction

endpackage

// File: rtl/sc_etu_tick.sv
module sc_etu_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last != '0) |=> !tick); // R10

endmodule

// File: rtl/sc_start_edge.sv
module sc_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic line_in,
  output logic start_fall
);

  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_in;
  end

  assign start_fall = armed && line_q && !line_in;

endmodule

// File: rtl/smartcard_char_link.sv
module smartcard_char_link #(
  parameter int OS        = 16,
  parameter int GUARD_ETU = 2,
  parameter int DIV_W     = 16,
  parameter int RETRY_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [RETRY_W-1:0] cfg_retries,
  input  logic               tx_valid,
  input  logic [7:0]         tx_data,
  output logic               tx_ready,
  output logic               tx_done,
  output logic               tx_fail,
  output logic               rx_valid,
  output logic [7:0]         rx_data,
  output logic               rx_parity_err,
  input  logic               line_in,
  output logic               line_drive_low
);
  import sc_char_pkg::*;

  localparam int SUB_W = (OS > 1) ? $clog2(OS) : 1;
  localparam int ETU_W = $clog2(12 + GUARD_ETU + 1);
  localparam logic [SUB_W-1:0] SUB_LAST   = SUB_W'(OS - 1);
  localparam logic [SUB_W-1:0] SUB_MID    = SUB_W'(OS / 2 - 1);
  localparam logic [ETU_W-1:0] E_DATA_END = ETU_W'(8);
  localparam logic [ETU_W-1:0] E_PAR      = ETU_W'(9);
  localparam logic [ETU_W-1:0] E_TEN      = ETU_W'(10);
  localparam logic [ETU_W-1:0] E_ELEVEN   = ETU_W'(11);
  localparam logic [ETU_W-1:0] E_DONE     = ETU_W'(9 + GUARD_ETU);
  localparam logic [ETU_W-1:0] E_RETRY    = ETU_W'(11 + GUARD_ETU);

  sc_state_e          state;
  logic [DIV_W-1:0]   div_q;
  logic [RETRY_W-1:0] retry_q;
  logic [RETRY_W-1:0] tries_left;
  logic [SUB_W-1:0]   sub;
  logic [ETU_W-1:0]   etu;
  logic [7:0]         tx_byte;
  logic [7:0]         rx_sh;
  logic [7:0]         rx_data_q;
  logic               drive_q, err_seen, par_bad;
  logic               done_q, fail_q, rxv_q, perr_q;

  // Named events shared by the FSM and the assertions.
  logic tick, start_fall, etu_step, mid_step, idle_now;

  assign idle_now = (state == ST_IDLE);
  assign etu_step = tick && (sub == SUB_LAST);
  assign mid_step = tick && (sub == SUB_MID);

  sc_etu_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(idle_now || !enable),
    .div(div_q), .tick(tick));

  sc_start_edge u_start (
    .clk(clk), .rst_n(rst_n), .armed(enable && idle_now),
    .line_in(line_in), .start_fall(start_fall));

  // Configuration is captured only while the block is disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(1);
      retry_q <= '0;
    end else if (!enable) begin
      div_q   <= cfg_div;
      retry_q <= cfg_retries;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;   sub <= '0;       etu <= '0;
      drive_q <= 1'b0;    tx_byte <= '0;   rx_sh <= '0;   rx_data_q <= '0;
      tries_left <= '0;   err_seen <= 1'b0; par_bad <= 1'b0;
      done_q <= 1'b0; fail_q <= 1'b0; rxv_q <= 1'b0; perr_q <= 1'b0;
    end else begin
      done_q <= 1'b0; fail_q <= 1'b0; rxv_q <= 1'b0; perr_q <= 1'b0;
      if (tick) begin
        if (sub == SUB_LAST) begin sub <= '0; etu <= etu + 1'b1; end
        else                  sub <= sub + 1'b1;
      end
      if (!enable) begin
        state <= ST_IDLE; drive_q <= 1'b0; sub <= '0; etu <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            sub <= '0; etu <= '0;
            if (tx_valid) begin
              state <= ST_TX; tx_byte <= tx_data; tries_left <= retry_q;
              drive_q <= 1'b1; err_seen <= 1'b0;
            end else if (start_fall) begin
              state <= ST_RX; par_bad <= 1'b0;
            end
          end
          ST_TX: begin
            if (etu_step) begin
              if (etu < E_PAR)        drive_q <= ~sc_frame_bit(tx_byte, 4'(etu) + 4'd1);
              else if (etu == E_PAR)  drive_q <= 1'b0;
              if (etu == E_TEN)       err_seen <= ~line_in;
              if (!err_seen && etu == E_DONE) begin
                done_q <= 1'b1; state <= ST_IDLE;
              end
              if (err_seen && etu == E_RETRY) begin
                if (tries_left != '0) begin
                  tries_left <= tries_left - 1'b1; etu <= '0;
                  drive_q <= 1'b1; err_seen <= 1'b0;
                end else begin
                  fail_q <= 1'b1; state <= ST_IDLE;
                end
              end
            end
          end
          ST_RX: begin
            if (mid_step) begin
              if (etu == '0) begin
                if (line_in) state <= ST_IDLE;
              end else if (etu <= E_DATA_END) rx_sh <= {line_in, rx_sh[7:1]};
              else if (etu == E_PAR)          par_bad <= sc_parity_bad(rx_sh, line_in);
              else if (etu == E_TEN && par_bad) drive_q <= 1'b1;
            end
            if (etu_step) begin
              if (etu == E_ELEVEN) drive_q <= 1'b0;
              if (etu == E_DONE) begin
                state <= ST_IDLE; rx_data_q <= rx_sh;
                if (par_bad) perr_q <= 1'b1;
                else         rxv_q  <= 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign tx_ready       = enable && idle_now;
  assign tx_done        = done_q;
  assign tx_fail        = fail_q;
  assign rx_valid       = rxv_q;
  assign rx_parity_err  = perr_q;
  assign rx_data        = rx_data_q;
  assign line_drive_low = drive_q;

  AST_RX_ERR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX && drive_q) |-> (etu == E_TEN || etu == E_ELEVEN)); // R8
  AST_TX_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && etu >= E_TEN) |-> !drive_q); // R2
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, fail_q, rxv_q, perr_q})); // R3
  AST_FAIL_NO_TRIES: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (tries_left == '0)); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(div_q) && $stable(retry_q))); // R10
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !drive_q); // R11

endmodule

// File: tb/tb_smartcard_char_link.sv
module tb_smartcard_char_link;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VECS [0:7] = '{
    16'h80A5, 16'h903C, 16'hA000, 16'hB0FF,
    16'h005A, 16'h0181, 16'h0000, 16'h017E };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [15:0] cfg_div = 16'd1;
  logic [2:0]  cfg_retries = 3'd0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic card_low = 1'b0;
  logic line_in;
  logic tx_ready, tx_done, tx_fail, rx_valid, rx_parity_err, line_drive_low;
  logic [7:0] rx_data;

  assign line_in = ~(line_drive_low | card_low);

  smartcard_char_link dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
    .cfg_retries(cfg_retries), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_fail(tx_fail),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
    .line_in(line_in), .line_drive_low(line_drive_low));

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_bad = 0;
  int n_done = 0, n_failev = 0, n_rxv = 0, n_perr = 0;
  always @(negedge clk) if (rst_n) begin
    if (tx_done) n_done++;
    if (tx_fail) n_failev++;
    if (rx_valid) n_rxv++;
    if (rx_parity_err) n_perr++;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int unsigned n);
    while (cyc < n) @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [7:0] d, input int k);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    if (k == 0) return 1'b0;
    if (k == 9) return (ones % 2) == 1;
    return d[k-1];
  endfunction

  task automatic configure(input logic [15:0] d, input logic [2:0] r);
    enable = 1'b0; cfg_div = d; cfg_retries = r;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  // Offer a byte; the card flags an error on the first n_err attempts.
  task automatic tx_run(input logic [7:0] d, input int n_err, input int retries, input int unsigned dv);
    int unsigned base;
    int a = 0;
    bit fin = 1'b0;
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0; base = cyc;
    while (!fin) begin
      for (int k = 0; k < 10; k++) begin
        wait_cyc(base + (16*k + 8)*dv);
        check("R2", "tx bit level", line_in, exp_bit(d, k));
      end
      wait_cyc(base + 165*dv);
      check("R2", "line released after parity", line_in, 1'b1);
      if (a < n_err) begin
        wait_cyc(base + 171*dv); card_low = 1'b1;   // late error edge, 10.68 etu
        wait_cyc(base + 192*dv); card_low = 1'b0;
        check("R3", "no done after error", tx_done, 1'b0);
        wait_cyc(base + 224*dv);
        if (a == retries) begin
          check("R6", "fail after last attempt", tx_fail, 1'b1);
          fin = 1'b1;
        end else begin
          check("R4", "resend start bit at 14 etu", line_in, 1'b0);
          check("R6", "no fail while retries left", tx_fail, 1'b0);
          base = base + 224*dv;
          a++;
        end
      end else begin
        wait_cyc(base + 192*dv - 1);
        check("R3", "done not early", tx_done, 1'b0);
        wait_cyc(base + 192*dv);
        check("R3", "done at 12 etu", tx_done, 1'b1);
        fin = 1'b1;
      end
    end
    @(negedge clk);
  endtask

  // Card sends a byte; bad flips the parity bit; glitch adds a late low pulse.
  task automatic rx_run(input logic [7:0] d, input logic bad, input logic glitch, input int unsigned dv);
    int unsigned base;
    card_low = 1'b1;
    @(negedge clk);
    base = cyc;
    for (int k = 1; k < 10; k++) begin
      wait_cyc(base - 1 + 16*k*dv);
      card_low = (k == 9) ? ~(exp_bit(d, 9) ^ bad) : ~d[k-1];
    end
    wait_cyc(base - 1 + 160*dv); card_low = 1'b0;
    if (glitch) begin
      wait_cyc(base + 172*dv); card_low = 1'b1;
      wait_cyc(base + 190*dv); card_low = 1'b0;
    end
    wait_cyc(base + 168*dv - 1);
    check(bad ? "R8" : "R7", "no drive before 10.5 etu", line_drive_low, 1'b0);
    wait_cyc(base + 168*dv);
    check(bad ? "R8" : "R7", "error drive at 10.5 etu", line_drive_low, bad);
    wait_cyc(base + 191*dv);
    check(bad ? "R8" : "R7", "error drive before 12 etu", line_drive_low, bad);
    check("R7", "no early rx_valid", rx_valid, 1'b0);
    wait_cyc(base + 192*dv);
    check("R8", "drive released at 12 etu", line_drive_low, 1'b0);
    check("R7", "rx_valid at 12 etu", rx_valid, !bad);
    check("R8", "parity error pulse", rx_parity_err, bad);
    if (!bad) check("R7", "rx_data", rx_data, d);
    @(negedge clk);
  endtask

  initial begin
    int snap;
    logic [15:0] v;
    repeat (4) @(negedge clk);
    check("R1", "drive in reset", line_drive_low, 1'b0);
    check("R1", "ready in reset", tx_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "events after reset", {tx_done, tx_fail, rx_valid, rx_parity_err}, 4'b0);
    check("R1", "ready while disabled", tx_ready, 1'b0);
    configure(16'd1, 3'd2);
    check("R1", "ready when enabled", tx_ready, 1'b1);
    check("R1", "line idle", line_drive_low, 1'b0);

    for (int i = 0; i < 8; i++) begin
      v = VECS[i];
      if (v[15]) tx_run(v[7:0], int'(v[14:12]), 2, 1);
      else       rx_run(v[7:0], v[8], 1'b0, 1);
      repeat (5) @(negedge clk);
    end

    // R5: late error with no retries must not look like a new character.
    configure(16'd1, 3'd0);
    snap = n_rxv + n_perr;
    tx_run(8'hC3, 1, 0, 1);
    repeat (400) @(negedge clk);
    check("R5", "no receive after late error", n_rxv + n_perr, snap);
    check("R5", "idle after fail", tx_ready, 1'b1);

    // R9: low pulse inside the guard window is ignored.
    configure(16'd1, 3'd2);
    rx_run(8'h33, 1'b0, 1'b1, 1);
    @(negedge clk);
    snap = n_done + n_failev + n_rxv + n_perr;
    repeat (400) @(negedge clk);
    check("R9", "no event from guard glitch", n_done + n_failev + n_rxv + n_perr, snap);
    check("R9", "no drive from guard glitch", line_drive_low, 1'b0);

    // R9: short low that is gone at mid start bit.
    card_low = 1'b1; repeat (4) @(negedge clk); card_low = 1'b0;
    repeat (300) @(negedge clk);
    check("R9", "false start dropped", n_done + n_failev + n_rxv + n_perr, snap);
    rx_run(8'hE7, 1'b0, 1'b0, 1);

    // R10: divider of 3, then a change while enabled is ignored.
    configure(16'd3, 3'd2);
    rx_run(8'h96, 1'b1, 1'b0, 3);
    tx_run(8'h4B, 1, 2, 3);
    cfg_div = 16'd7; cfg_retries = 3'd0;
    @(negedge clk);
    tx_run(8'h12, 2, 2, 3);

    // R11: disable in the middle of a character.
    tx_valid = 1'b1; tx_data = 8'hAA;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (50) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R11", "line released on disable", line_drive_low, 1'b0);
    check("R11", "not ready when disabled", tx_ready, 1'b0);
    snap = n_done + n_failev + n_rxv + n_perr;
    enable = 1'b1;
    @(negedge clk);
    check("R11", "ready after re-enable", tx_ready, 1'b1);
    repeat (300) @(negedge clk);
    check("R11", "aborted character gives no event", n_done + n_failev + n_rxv + n_perr, snap);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  end

endmodule